// File: doc/BRIEF.md
# HDLC Flag and Zero-Insertion Transmitter

This block turns a stream of frame octets into a synchronous serial bit stream for a bit-oriented link. It wraps each frame in flag patterns (a zero, six ones, a zero). Inside the frame it adds a zero after every run of five ones, so payload bits can never look like a flag. When no frame is waiting, the line carries flags back to back. A frame is cut short with an abort pattern of unbroken ones when the upstream side asks for it, or when the next octet has not arrived by the time the line needs it.

Octets come in over a valid/ready handshake, with start-of-frame and end-of-frame markers on the same beat. One line bit is produced for each cycle in which the bit enable is high. The frame check sequence must already sit at the end of the octet stream. The block only frames the octets and applies zero insertion; it does not inspect them.

Top module: `hdlc_stuff_tx`

## Requirements
- R1: After reset, and whenever no frame is open, the line carries back-to-back flags. Each flag is the 8 bits 0,1,1,1,1,1,1,0 in line order, and the first line bit after reset is the first bit of a flag.
- R2: Within frame content, a run of 1 bits never reaches six. The ones count carries across octet boundaries and restarts on any 0 bit, whether data or inserted.
- R3: The inserted 0 goes out on the bit tick right after the fifth consecutive content 1. This also applies when that 1 is the last bit of the final octet, so the inserted 0 comes before the closing flag.
- R4: Flag bits are never subject to zero insertion: the six ones of every flag go out unbroken.
- R5: `in_ready` is high only in a cycle where `bit_en` is high. An octet is taken at a rising clock edge where `in_valid` and `in_ready` are both high. Octets go out least-significant bit first.
- R6: No octet is accepted on a tick that sends an inserted 0. Consecutive octet handshakes within a frame are therefore 8 bit ticks apart, plus one tick for each inserted zero between them.
- R7: The octet marked end-of-frame is followed by one closing flag. An octet marked start-of-frame that is pending is taken on the last bit of that flag, so back-to-back frames share a single flag: 16 bit ticks separate the handshakes of two one-octet frames with zero content.
- R8: A high `abort_req` on a bit tick while a frame is open starts an abort on that same tick. The abort is 7 consecutive 1 bits, with `tx_abort` high on exactly those bits, and flags follow it.
- R9: When an octet of an open frame, other than the end-of-frame octet, finishes and `in_valid` is low, the frame is aborted with the same 7-ones pattern instead of stalling the line.
- R10: `abort_req` has no effect while no frame is open. An octet without the start-of-frame marker that is offered outside a frame is taken at a flag boundary and discarded, without opening a frame.
- R11: `tx_bit` and `tx_abort` are 0 after reset and change only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit tick: one line bit per cycle with this high |
| in_valid | input | 1 | Octet on `in_data` is offered |
| in_data | input | OCTET_W | Octet to send, bit 0 goes out first |
| in_sof | input | 1 | Offered octet opens a frame |
| in_eof | input | 1 | Offered octet closes the frame |
| in_ready | output | 1 | Octet is taken at this edge when `in_valid` is high |
| abort_req | input | 1 | Request to abort the open frame |
| tx_bit | output | 1 | Serial line bit |
| tx_abort | output | 1 | High while abort ones are on the line |

## Verification
Two pairs of events can land on the same bit tick. The first is zero insertion and the octet handoff. The second is zero insertion and the closing flag. Frames are chosen so that a run of five ones ends exactly at an octet edge (0xF0 followed by 0x01) and on the last bit of the final octet (0xF8). The first case is judged from the spacing of handshake ticks, which must grow by one. The second is judged from the recorded line bits, where a 0 must come before an unbroken flag. An abort request in the middle of a frame and a late octet at a boundary are both judged by the exact count of `tx_abort` bits and by an independent receive decoder that sees the abort and delivers no frame.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;

   typedef enum logic [1:0] {
      ST_FLAG  = 2'd0,
      ST_DATA  = 2'd1,
      ST_ABORT = 2'd2
   } tx_state_e;

   // Flag is a zero, (run+1) ones, a zero; idx counts line order.
   function automatic logic flag_bit(input int idx, input int run);
      return (idx != 0) && (idx != run + 2);
   endfunction

endpackage

// File: rtl/hdlc_run_counter.sv
`timescale 1ns/1ps
module hdlc_run_counter #(
   parameter int RUN = 5,
   parameter int CW  = $clog2(RUN + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          clr,
   input  logic          one_bit,
   output logic [CW-1:0] count,
   output logic          full
);

   localparam logic [CW-1:0] RUN_V = CW'(RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         if (clr || !one_bit) count <= '0;
         else                 count <= count + 1'b1;
      end
   end

   assign full = (count == RUN_V);

endmodule

// File: rtl/hdlc_octet_shifter.sv
`timescale 1ns/1ps
module hdlc_octet_shifter #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic         cur_bit
);

   logic [W-1:0] sh;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)     sh <= '0;
            else if (load)  sh <= din;
            else if (shift) sh <= {sh[W-2:0], 1'b0};
         end
         assign cur_bit = sh[W-1];
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)     sh <= '0;
            else if (load)  sh <= din;
            else if (shift) sh <= {1'b0, sh[W-1:1]};
         end
         assign cur_bit = sh[0];
      end
   endgenerate

endmodule

// File: rtl/hdlc_stuff_tx.sv
`timescale 1ns/1ps
module hdlc_stuff_tx
   import hdlc_tx_pkg::*;
#(
   parameter int OCTET_W    = 8,
   parameter int STUFF_RUN  = 5,
   parameter int ABORT_ONES = 7,
   parameter bit MSB_FIRST  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic               in_valid,
   input  logic [OCTET_W-1:0] in_data,
   input  logic               in_sof,
   input  logic               in_eof,
   output logic               in_ready,
   input  logic               abort_req,
   output logic               tx_bit,
   output logic               tx_abort
);

   localparam int FLAG_LEN = STUFF_RUN + 3;
   localparam int M1       = (OCTET_W > FLAG_LEN) ? OCTET_W : FLAG_LEN;
   localparam int POS_MAX  = (M1 > ABORT_ONES) ? M1 : ABORT_ONES;
   localparam int PW       = $clog2(POS_MAX);
   localparam int CW       = $clog2(STUFF_RUN + 2);

   localparam logic [PW-1:0] LAST_DATA  = PW'(OCTET_W - 1);
   localparam logic [PW-1:0] LAST_FLAG  = PW'(FLAG_LEN - 1);
   localparam logic [PW-1:0] LAST_ABORT = PW'(ABORT_ONES - 1);

   generate
      if (OCTET_W < 2) begin : g_bad_width
         $error("OCTET_W must be at least 2");
      end
      if (STUFF_RUN < 1) begin : g_bad_run
         $error("STUFF_RUN must be at least 1");
      end
      if (ABORT_ONES < STUFF_RUN + 2) begin : g_bad_abort
         $error("ABORT_ONES must exceed the flag's run of ones");
      end
   endgenerate

   tx_state_e     state, state_nx;
   logic [PW-1:0] pos, pos_nx;
   logic          cur_eof, eof_nx;
   logic [CW-1:0] ones_cnt;
   logic          run_full;
   logic          cur_bit;
   logic          bit_nx, abt_nx;
   logic          load_byte, shift_byte;
   logic          ones_clr, ones_one;
   logic          take;

   hdlc_run_counter #(.RUN(STUFF_RUN), .CW(CW)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bit_en),
      .clr     (ones_clr),
      .one_bit (ones_one),
      .count   (ones_cnt),
      .full    (run_full)
   );

   hdlc_octet_shifter #(.W(OCTET_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_byte),
      .shift   (shift_byte),
      .din     (in_data),
      .cur_bit (cur_bit)
   );

   always_comb begin
      state_nx   = state;
      pos_nx     = pos;
      eof_nx     = cur_eof;
      bit_nx     = tx_bit;
      abt_nx     = 1'b0;
      load_byte  = 1'b0;
      shift_byte = 1'b0;
      ones_clr   = 1'b0;
      ones_one   = 1'b0;
      take       = 1'b0;
      if (bit_en) begin
         case (state)
            ST_FLAG: begin
               ones_clr = 1'b1;
               if (run_full) begin
                  // zero owed by the last content bits, before the flag
                  bit_nx = 1'b0;
               end else begin
                  bit_nx = flag_bit(32'(pos), STUFF_RUN);
                  if (pos == LAST_FLAG) begin
                     take   = 1'b1;
                     pos_nx = '0;
                     if (in_valid && in_sof) begin
                        load_byte = 1'b1;
                        eof_nx    = in_eof;
                        state_nx  = ST_DATA;
                     end
                  end else begin
                     pos_nx = pos + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (abort_req) begin
                  bit_nx   = 1'b1;
                  abt_nx   = 1'b1;
                  ones_clr = 1'b1;
                  state_nx = ST_ABORT;
                  pos_nx   = PW'(1);
               end else if (run_full) begin
                  bit_nx = 1'b0;
               end else begin
                  bit_nx     = cur_bit;
                  ones_one   = cur_bit;
                  shift_byte = 1'b1;
                  if (pos == LAST_DATA) begin
                     pos_nx = '0;
                     if (cur_eof) begin
                        state_nx = ST_FLAG;
                     end else if (in_valid) begin
                        take      = 1'b1;
                        load_byte = 1'b1;
                        eof_nx    = in_eof;
                     end else begin
                        state_nx = ST_ABORT;
                     end
                  end else begin
                     pos_nx = pos + 1'b1;
                  end
               end
            end
            ST_ABORT: begin
               bit_nx   = 1'b1;
               abt_nx   = 1'b1;
               ones_clr = 1'b1;
               if (pos == LAST_ABORT) begin
                  state_nx = ST_FLAG;
                  pos_nx   = '0;
               end else begin
                  pos_nx = pos + 1'b1;
               end
            end
            default: begin
               ones_clr = 1'b1;
               state_nx = ST_FLAG;
               pos_nx   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_FLAG;
         pos      <= '0;
         cur_eof  <= 1'b0;
         tx_bit   <= 1'b0;
         tx_abort <= 1'b0;
      end else begin
         state   <= state_nx;
         pos     <= pos_nx;
         cur_eof <= eof_nx;
         if (bit_en) begin
            tx_bit   <= bit_nx;
            tx_abort <= abt_nx;
         end
      end
   end

   assign in_ready = take;

endmodule

// File: rtl/hdlc_stuff_tx_chk.sv
`timescale 1ns/1ps
module hdlc_stuff_tx_chk
   import hdlc_tx_pkg::*;
#(
   parameter int STUFF_RUN = 5,
   parameter int CW        = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_en,
   input logic          in_ready,
   input logic          abort_req,
   input logic          tx_bit,
   input logic          tx_abort,
   input tx_state_e     state,
   input logic [CW-1:0] ones_cnt
);

   localparam logic [CW-1:0] RUN_V = CW'(STUFF_RUN);

   // R2: the content run counter never passes the stuffing limit
   a_r2_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ones_cnt <= RUN_V);

   // R3: a full run is followed by a zero on the line
   a_r3_zero_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && ones_cnt == RUN_V &&
       (state == ST_FLAG || (state == ST_DATA && !abort_req))) |=> !tx_bit);

   // R5: handshake only on a bit tick
   a_r5_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> bit_en);

   // R6: no octet taken while an inserted zero is due
   a_r6_no_take_on_stuff: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_ABORT && ones_cnt == RUN_V) |-> !in_ready);

   // R8: abort marker only over one bits
   a_r8_abort_is_ones: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> tx_bit);

   // R9: no octet taken during an abort
   a_r9_no_take_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ABORT) |-> !in_ready);

   // R11: line outputs move only on bit ticks
   a_r11_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(tx_bit) && $stable(tx_abort)));

endmodule

bind hdlc_stuff_tx hdlc_stuff_tx_chk #(.STUFF_RUN(STUFF_RUN), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .in_ready  (in_ready),
   .abort_req (abort_req),
   .tx_bit    (tx_bit),
   .tx_abort  (tx_abort),
   .state     (state),
   .ones_cnt  (ones_cnt)
);

// File: tb/sim_hdlc_stuff_tx.sv
`timescale 1ns/1ps
module sim_hdlc_stuff_tx;

   localparam int RUN = 5;
   localparam int AB  = 7;
   localparam int NV  = 6;
   localparam int  V_LEN [NV] = '{1, 2, 3, 4, 1, 4};
   localparam logic [31:0] V_DAT [NV] = '{
      32'h0000_007E, 32'h0000_FFFF, 32'h0001_F07C,
      32'h3E7C_F81F, 32'h0000_0000, 32'hA5C3_FF7E};

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_sof = 1'b0;
   logic       in_eof = 1'b0;
   logic       in_ready;
   logic       abort_req = 1'b0;
   logic       tx_bit;
   logic       tx_abort;

   hdlc_stuff_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
      .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
      .abort_req(abort_req), .tx_bit(tx_bit), .tx_abort(tx_abort));

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // stimulus source and bit capture
   logic [9:0] src_q[$];
   int  fire_t[$];
   bit  raw [0:8191];
   int  tick_n = 0, samp_idx = 0, cyc = 0, en_div = 1;
   bit  samp_pend = 1'b0, hold_en = 1'b0;
   int  abort_ticks = 0;

   // independent receive decoder
   bit         rx_buf [0:2047];
   int         rx_nb = 0, rx_ones = 0, rx_frames = 0, rx_aborts = 0;
   int         rx_misalign = 0, rx_len = 0;
   bit         rx_in = 1'b0;
   logic [7:0] rx_bytes [0:15];

   task rx_deliver();
      int nbits;
      nbits = rx_nb - 7;
      if (nbits % 8 != 0) rx_misalign++;
      rx_len = nbits / 8;
      for (int k = 0; k < rx_len && k < 16; k++)
         for (int j = 0; j < 8; j++) rx_bytes[k][j] = rx_buf[8*k + j];
      rx_frames++;
   endtask

   task rx_bit(input logic b);
      if (b) begin
         rx_ones++;
         if (rx_ones == AB && rx_in) begin
            rx_aborts++;
            rx_in = 1'b0;
         end else if (rx_in && rx_ones < AB && rx_nb < 2048) begin
            rx_buf[rx_nb] = 1'b1;
            rx_nb++;
         end
      end else begin
         if (rx_ones == RUN + 1) begin
            if (rx_in && rx_nb > 7) rx_deliver();
            rx_in = 1'b1;
            rx_nb = 0;
         end else if (rx_ones < RUN && rx_in && rx_nb < 2048) begin
            rx_buf[rx_nb] = 1'b0;
            rx_nb++;
         end
         rx_ones = 0;
      end
   endtask

   always @(posedge clk) begin
      if (bit_en && rst_n) begin
         samp_idx  = tick_n;
         samp_pend = 1'b1;
         if (in_valid && in_ready) begin
            fire_t.push_back(tick_n);
            void'(src_q.pop_front());
         end
         tick_n++;
      end
   end

   always @(negedge clk) begin
      if (samp_pend) begin
         if (samp_idx < 8192) raw[samp_idx] = tx_bit;
         if (tx_abort) abort_ticks++;
         rx_bit(tx_bit);
         samp_pend = 1'b0;
      end
      cyc++;
      bit_en = rst_n && !hold_en && (cyc % en_div == 0);
      in_valid = (src_q.size() > 0);
      if (in_valid) {in_sof, in_eof, in_data} = src_q[0];
      else          {in_sof, in_eof, in_data} = '0;
   end

   task automatic push_frame(input int n, input logic [31:0] v);
      for (int i = 0; i < n; i++)
         src_q.push_back({(i == 0), (i == n - 1), v[8*i +: 8]});
   endtask

   task automatic wait_frames(input int target);
      int g = 0;
      while (rx_frames < target && g < 4000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic wait_fires(input int target);
      int g = 0;
      while (fire_t.size() < target && g < 4000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic check_frame(input int n, input logic [31:0] v, input string tag);
      chk(rx_len == n, {tag, " frame length"}, rx_len, n);
      for (int i = 0; i < n && i < rx_len; i++)
         chk(rx_bytes[i] == v[8*i +: 8], {tag, " octet"}, rx_bytes[i], v[8*i +: 8]);
      chk(rx_misalign == 0, {tag, " bit count"}, rx_misalign, 0);
   endtask

   function automatic bit flag_exp(input int k);
      return (k != 0) && (k != 7);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick_n, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int nf, rf, ra, ab0, t, mism;
      logic b0;
      repeat (4) @(negedge clk);
      // R11 reset state, R5 no ready without a tick
      chk(tx_bit == 1'b0, "R11 reset tx_bit", tx_bit, 0);
      chk(tx_abort == 1'b0, "R11 reset tx_abort", tx_abort, 0);
      chk(in_ready == 1'b0, "R5 ready in reset", in_ready, 0);
      rst_n = 1'b1;
      repeat (24) @(negedge clk);

      // R1 and R4: two idle flags first, ones unbroken
      mism = 0;
      for (int k = 0; k < 16; k++) if (raw[k] != flag_exp(k % 8)) mism++;
      chk(mism == 0, "R1 R4 idle flags", mism, 0);

      // table of frames, R2 and R5 content through decoder
      for (int i = 0; i < NV; i++) begin
         en_div = (i % 2 == 1) ? 3 : 1;
         repeat (3) @(negedge clk);
         rf = rx_frames;
         push_frame(V_LEN[i], V_DAT[i]);
         wait_frames(rf + 1);
         check_frame(V_LEN[i], V_DAT[i], "R2 R5 table");
         chk(rx_aborts == 0, "R2 no stray abort", rx_aborts, 0);
      end
      en_div = 1;
      repeat (3) @(negedge clk);

      // R6: run of ones in one octet costs one tick
      nf = fire_t.size(); rf = rx_frames;
      push_frame(3, 32'h0000_00FF);
      wait_frames(rf + 1);
      chk(fire_t[nf+1] - fire_t[nf] == 9, "R6 gap after 0xFF", fire_t[nf+1] - fire_t[nf], 9);
      chk(fire_t[nf+2] - fire_t[nf+1] == 8, "R6 gap after 0x00", fire_t[nf+2] - fire_t[nf+1], 8);

      // R2: run carried across an octet edge
      nf = fire_t.size(); rf = rx_frames;
      push_frame(3, 32'h0000_01F0);
      wait_frames(rf + 1);
      chk(fire_t[nf+2] - fire_t[nf+1] == 9, "R2 carry across octets", fire_t[nf+2] - fire_t[nf+1], 9);
      check_frame(3, 32'h0000_01F0, "R2 carry");

      // R3: inserted zero before the closing flag
      nf = fire_t.size(); rf = rx_frames;
      push_frame(2, 32'h0000_F800);
      wait_frames(rf + 1);
      t = fire_t[nf+1];
      chk(raw[t+9] == 1'b0, "R3 zero after final run", raw[t+9], 0);
      mism = 0;
      for (int k = 0; k < 8; k++) if (raw[t+10+k] != flag_exp(k)) mism++;
      chk(mism == 0, "R4 closing flag intact", mism, 0);

      // R7: back-to-back frames share one flag
      nf = fire_t.size(); rf = rx_frames;
      push_frame(1, 32'h0);
      push_frame(1, 32'h0);
      wait_frames(rf + 2);
      chk(fire_t[nf+1] - fire_t[nf] == 16, "R7 shared flag spacing", fire_t[nf+1] - fire_t[nf], 16);
      chk(rx_frames == rf + 2, "R7 both frames", rx_frames, rf + 2);

      // R11: no tick, no change
      nf = fire_t.size(); rf = rx_frames;
      push_frame(4, 32'h5A3C_96E1);
      wait_fires(nf + 2);
      hold_en = 1'b1;
      repeat (2) @(negedge clk);
      b0 = tx_bit; mism = 0;
      repeat (5) begin
         @(negedge clk);
         if (tx_bit != b0 || in_ready) mism++;
      end
      chk(mism == 0, "R11 hold without tick", mism, 0);
      hold_en = 1'b0;
      wait_frames(rf + 1);
      check_frame(4, 32'h5A3C_96E1, "R11 frame after hold");

      // R8: abort request mid frame
      repeat (3) @(negedge clk);
      nf = fire_t.size(); rf = rx_frames; ra = rx_aborts; ab0 = abort_ticks;
      push_frame(4, 32'h0);
      wait_fires(nf + 2);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      repeat (60) @(negedge clk);
      chk(abort_ticks - ab0 == AB, "R8 abort length", abort_ticks - ab0, AB);
      chk(rx_aborts == ra + 1, "R8 abort seen", rx_aborts, ra + 1);
      chk(rx_frames == rf, "R8 no frame delivered", rx_frames, rf);
      chk(src_q.size() == 0, "R10 leftover octets drained", src_q.size(), 0);

      // R9: late octet aborts the frame
      rf = rx_frames; ra = rx_aborts; ab0 = abort_ticks;
      src_q.push_back({1'b1, 1'b0, 8'h33});
      repeat (60) @(negedge clk);
      chk(abort_ticks - ab0 == AB, "R9 underrun abort length", abort_ticks - ab0, AB);
      chk(rx_aborts == ra + 1, "R9 underrun abort seen", rx_aborts, ra + 1);
      chk(rx_frames == rf, "R9 no frame delivered", rx_frames, rf);

      // R10: abort request and stray octet outside a frame
      ab0 = abort_ticks; nf = fire_t.size();
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      repeat (30) @(negedge clk);
      chk(abort_ticks == ab0, "R10 idle abort ignored", abort_ticks - ab0, 0);
      src_q.push_back({1'b0, 1'b1, 8'h7E});
      repeat (40) @(negedge clk);
      chk(fire_t.size() == nf + 1, "R10 stray octet taken", fire_t.size() - nf, 1);
      chk(rx_frames == rf, "R10 stray octet opens nothing", rx_frames, rf);
      push_frame(2, 32'h0000_C0DE);
      wait_frames(rf + 1);
      check_frame(2, 32'h0000_C0DE, "R10 frame after stray");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule